// File: doc/BRIEF.md
# Statically Scheduled Tile Crossbar Switch

This block is the communication interface of one tile in a mesh of cores. It has five streaming links: four toward the neighbouring tiles (north, south, east, west) and one toward the tile's own core. Every output link is fed through a crossbar from any one of the five input links. The source of each output is not chosen by headers or by arbitration. A cyclic schedule held in a small instruction memory fixes it, so every transfer takes a known number of cycles.

A controller steps a slot counter through the schedule, one slot per clock. It returns to slot 0 after the slot whose number equals a programmable last-slot register, so the schedule repeats. Each instruction word names a source for every output, and one input may drive several outputs in the same slot. The schedule memory and the last-slot register are loaded through a configuration write port while the schedule is stopped. Raising the run enable starts the schedule from slot 0. Each output is a register stage with a valid bit, so a word advances one tile per cycle.

Top module: `tile_xbar_switch`

## Requirements
- R1: While reset is held and after it is released, with run enable low, every out_valid bit is 0 and every out_data word is 0.
- R2: Port index p is 0 north, 1 south, 2 east, 3 west, 4 core, for inputs and outputs alike. Output o takes its source from instruction bits [3o+2:3o], and codes 1 to 5 select input (code-1).
- R3: A field holding code 0, 6 or 7 leaves its output idle in that slot: valid 0 and data 0.
- R4: One input selected by several fields in the same instruction appears on all of those outputs in the same cycle.
- R5: An output's valid equals the in_valid of its selected source, sampled at the clock edge that loads the output. Its data is that input's word when valid and 0 otherwise.
- R6: At the first clock edge that samples run_en high after it was low, slot 0 becomes current, and the outputs loaded at that edge are all idle. Inputs present at the next edge are routed by slot 0.
- R7: Each later edge with run_en high advances the slot by one. After the slot equal to the last-slot register, the next slot is 0, so the schedule has a period of last-slot plus one.
- R8: After run_en is sampled low, all outputs are idle from the second clock edge on. A later start begins again at slot 0.
- R9: Writes to the schedule memory (cfg_we) and to the last-slot register (cfg_len_we) take effect only at edges where run_en is low. At edges where run_en is high they change nothing that later routing shows.
- R10: A last-slot value of 0 applies slot 0 in every cycle. The last-slot register resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Runs the schedule when high; configuration is accepted when low |
| cfg_we | input | 1 | Schedule memory write strobe |
| cfg_addr | input | AW | Slot written by cfg_we |
| cfg_wdata | input | 15 | Instruction word: five 3-bit source fields |
| cfg_len_we | input | 1 | Last-slot register write strobe |
| cfg_len | input | AW | Number of the last slot before wrap |
| in_valid | input | 5 | Valid per input link, indexed by port |
| in_data | input | 5 x DW | Data word per input link |
| out_valid | output | 5 | Registered valid per output link |
| out_data | output | 5 x DW | Registered data word per output link |

## Verification
The hardest situation to reach is a configuration write that arrives while the schedule runs, because its effect is to do nothing. Only routing in later slots can reveal it. The stimulus issues random memory and last-slot writes on every cycle of one long run and keeps the bench's schedule model unchanged, so any leak shows up as a routing mismatch in a later period. The wrap point and restart are reached with randomly chosen last-slot values, including 0 and the deepest slot, and with stop and start sequences between runs.

// File: rtl/tile_xbar_pkg.sv
package tile_xbar_pkg;
  localparam int NPORT = 5;
  localparam int SELW  = 3;
  localparam int IW    = NPORT * SELW;

  typedef enum logic [SELW-1:0] {
    SRC_IDLE  = 3'd0,
    SRC_NORTH = 3'd1,
    SRC_SOUTH = 3'd2,
    SRC_EAST  = 3'd3,
    SRC_WEST  = 3'd4,
    SRC_CORE  = 3'd5
  } src_sel_e;

  // source code that selects input port p
  function automatic logic [SELW-1:0] port_code(input int p);
    return SELW'(p + 1);
  endfunction
endpackage

// File: rtl/xbar_sched_ctrl.sv
module xbar_sched_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          len_we,
  input  logic [AW-1:0] len_in,
  output logic [AW-1:0] rd_addr,
  output logic          rd_en,
  output logic          act
);
  logic [AW-1:0] pc;
  logic [AW-1:0] len_q;
  logic [AW-1:0] slot_nxt;

  // slot that becomes current at the next edge
  always_comb begin
    if (!act)               slot_nxt = '0;
    else if (pc == len_q)   slot_nxt = '0;
    else                    slot_nxt = pc + AW'(1);
  end

  assign rd_addr = slot_nxt;
  assign rd_en   = run_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      act   <= 1'b0;
      len_q <= '0;
    end else begin
      act <= run_en;
      pc  <= run_en ? slot_nxt : '0;
      if (len_we && !run_en) len_q <= len_in;
    end
  end

  a_r7_pc_in_range: assert property (@(posedge clk) disable iff (rst)
    act |-> (pc <= len_q));
  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (act && $past(act) && ($past(pc) == $past(len_q))) |-> (pc == '0));
  a_r8_restart_slot0: assert property (@(posedge clk) disable iff (rst)
    $rose(act) |-> (pc == '0));
  a_r9_len_frozen: assert property (@(posedge clk) disable iff (rst)
    (act && $past(act)) |-> $stable(len_q));
endmodule

// File: rtl/xbar_instr_mem.sv
module xbar_instr_mem #(
  parameter int AW = 4,
  parameter int IW = 15
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  a_r9_no_write_during_read: assert property (@(posedge clk)
    !(we && re));
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import tile_xbar_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      act,
  input  logic [IW-1:0]             instr,
  input  logic [NPORT-1:0]          in_valid,
  input  logic [NPORT-1:0][DW-1:0]  in_data,
  output logic [NPORT-1:0]          out_valid,
  output logic [NPORT-1:0][DW-1:0]  out_data
);
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [SELW-1:0] sel;
    logic            src_v;
    logic [DW-1:0]   src_d;

    assign sel = instr[o*SELW +: SELW];

    always_comb begin
      src_v = 1'b0;
      src_d = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (sel == port_code(p)) begin
          src_v = in_valid[p];
          src_d = in_data[p];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid[o] <= 1'b0;
        out_data[o]  <= '0;
      end else begin
        out_valid[o] <= act && src_v;
        out_data[o]  <= (act && src_v) ? src_d : '0;
      end
    end

    a_r8_idle_when_stopped: assert property (@(posedge clk) disable iff (rst)
      !act |=> !out_valid[o]);
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !out_valid[o] |-> (out_data[o] == '0));
  end
endmodule

// File: rtl/tile_xbar_switch.sv
module tile_xbar_switch
  import tile_xbar_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run_en,
  input  logic                      cfg_we,
  input  logic [AW-1:0]             cfg_addr,
  input  logic [IW-1:0]             cfg_wdata,
  input  logic                      cfg_len_we,
  input  logic [AW-1:0]             cfg_len,
  input  logic [NPORT-1:0]          in_valid,
  input  logic [NPORT-1:0][DW-1:0]  in_data,
  output logic [NPORT-1:0]          out_valid,
  output logic [NPORT-1:0][DW-1:0]  out_data
);
  logic [AW-1:0] rd_addr;
  logic          rd_en;
  logic          act;
  logic [IW-1:0] instr;
  logic          mem_we;

  assign mem_we = cfg_we && !run_en;

  xbar_sched_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .len_we  (cfg_len_we),
    .len_in  (cfg_len),
    .rd_addr (rd_addr),
    .rd_en   (rd_en),
    .act     (act)
  );

  xbar_instr_mem #(.AW(AW), .IW(IW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (cfg_addr),
    .wdata (cfg_wdata),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (instr)
  );

  xbar_switch #(.DW(DW)) u_xbar (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .instr     (instr),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  a_r6_first_edge_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(act) |-> (out_valid == '0));
endmodule

// File: tb/test_tile_xbar_switch.sv
`timescale 1ns/1ps
module test_tile_xbar_switch;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int NP = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [14:0] cfg_wdata = '0;
  logic cfg_len_we = 1'b0;
  logic [AW-1:0] cfg_len = '0;
  logic [NP-1:0] in_valid = '0;
  logic [NP-1:0][DW-1:0] in_data = '0;
  logic [NP-1:0] out_valid;
  logic [NP-1:0][DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [14:0] model_mem [DEPTH];
  int model_len = 0;

  always #2 clk = ~clk;

  tile_xbar_switch #(.DW(DW), .AW(AW)) i_tile_xbar_switch (
    .clk(clk), .rst(rst), .run_en(run_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [NP-1:0] pred_valid(logic [14:0] w, logic [NP-1:0] iv);
    logic [NP-1:0] r = '0;
    for (int o = 0; o < NP; o++) begin
      int c = int'(w[o*3 +: 3]);
      if (c >= 1 && c <= NP) r[o] = iv[c-1];
    end
    return r;
  endfunction

  function automatic logic [NP-1:0][DW-1:0] pred_data(logic [14:0] w, logic [NP-1:0] iv,
                                                     logic [NP-1:0][DW-1:0] id);
    logic [NP-1:0][DW-1:0] r = '0;
    for (int o = 0; o < NP; o++) begin
      int c = int'(w[o*3 +: 3]);
      if (c >= 1 && c <= NP && iv[c-1]) r[o] = id[c-1];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [NP-1:0] ev, logic [NP-1:0][DW-1:0] ed);
    checks++;
    if (out_valid !== ev || out_data !== ed) begin
      errors++;
      $display("FAIL %s: valid %b data %h, expected valid %b data %h",
               tag, out_valid, out_data, ev, ed);
    end
  endtask

  task automatic cfg_write(int addr, logic [14:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = w;
    model_mem[addr] = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic len_write(int l);
    @(negedge clk);
    cfg_len_we = 1'b1; cfg_len = AW'(l);
    model_len = l;
    @(negedge clk);
    cfg_len_we = 1'b0;
  endtask

  task automatic drive_inputs(int vmode);
    for (int p = 0; p < NP; p++) in_data[p] = DW'($urandom);
    case (vmode)
      0: in_valid = NP'($urandom);
      1: in_valid = '1;
      default: in_valid = '0;
    endcase
  endtask

  // run the schedule for n slots, checking each output cycle
  task automatic run_sched(string tag, int n, int vmode, bit noise);
    int slot = 0;
    logic [NP-1:0] ev;
    logic [NP-1:0][DW-1:0] ed;
    @(negedge clk);
    run_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R6 first edge idle", '0, '0);
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        @(negedge clk);
        check(tag, ev, ed);
      end
      drive_inputs(vmode);
      ev = pred_valid(model_mem[slot], in_valid);
      ed = pred_data(model_mem[slot], in_valid, in_data);
      slot = (slot == model_len) ? 0 : slot + 1;
      if (noise) begin
        // R9: writes while running must be ignored; model untouched
        cfg_we = 1'b1; cfg_addr = AW'($urandom); cfg_wdata = 15'($urandom);
        cfg_len_we = 1'b1; cfg_len = AW'($urandom);
      end
    end
    @(negedge clk);
    check(tag, ev, ed);
    cfg_we = 1'b0; cfg_len_we = 1'b0;
    run_en = 1'b0;
    in_valid = '1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R8 stopped outputs idle", '0, '0);
    in_valid = '0;
  endtask

  task automatic program_random(int l);
    for (int a = 0; a < DEPTH; a++) cfg_write(a, 15'($urandom));
    len_write(l);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int a = 0; a < DEPTH; a++) model_mem[a] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset held", '0, '0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 after reset", '0, '0);

    // R2: each output from a different source; N<-S, S<-E, E<-W, W<-Core, Core<-N
    cfg_write(0, {3'd1, 3'd5, 3'd4, 3'd3, 3'd2});
    len_write(0);
    run_sched("R2 source mapping", 6, 0, 1'b0);

    // R4: north broadcast to all outputs
    cfg_write(0, {3'd1, 3'd1, 3'd1, 3'd1, 3'd1});
    run_sched("R4 broadcast", 4, 1, 1'b0);

    // R3: idle codes 0, 6, 7 with all inputs valid
    cfg_write(0, {3'd0, 3'd6, 3'd7, 3'd6, 3'd0});
    run_sched("R3 idle codes", 4, 1, 1'b0);

    // R5: inputs never valid -> outputs idle, data zero
    cfg_write(0, {3'd5, 3'd4, 3'd3, 3'd2, 3'd1});
    run_sched("R5 valid follows source", 4, 2, 1'b0);

    // R10: single-slot schedule with random word
    cfg_write(0, 15'($urandom));
    run_sched("R10 length zero", 8, 0, 1'b0);

    // R7: random schedules with several lengths, restart from slot 0 each time
    program_random(5);
    run_sched("R7 wrap len5", 30, 0, 1'b0);
    program_random(DEPTH - 1);
    run_sched("R7 wrap full depth", 40, 0, 1'b0);
    len_write(1);
    run_sched("R7 wrap len1", 10, 1, 1'b0);

    // R9: configuration noise during a long run
    program_random(6);
    run_sched("R9 writes ignored while running", 60, 0, 1'b1);
    run_sched("R9 schedule intact after noise", 20, 0, 1'b0);

    // R8: restart sequence after stop uses slot 0 again
    run_sched("R8 restart", 12, 0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule